// File: doc/BRIEF.md
# Thermal Foldback and Overtemperature Supervisor

This block watches a digital junction-temperature code once per clock and turns it into three control decisions for a motor-bridge power stage. It asks the current limiter for a reduced threshold while the die is hot but still allowed to run. It latches an overtemperature fault once the shutdown trip point is reached, and the power stage turns its outputs off on that signal. It also decides whether a request to clear that fault may be granted.

The temperature code is registered on entry, and every comparison uses the registered value. The foldback request has its own small hysteresis so the current-limit select does not chatter near its threshold. A latched fault can be cleared from two sources, which are judged differently. A rising edge on the enable-path request is granted as soon as the code is below the trip point. A rising edge on the disable-path request is granted only when the code is below the trip point minus the shutdown hysteresis. A granted request clears the latch and raises a one-cycle acknowledge. A refused request leaves the latch set, and holding the request high does not retry it. All thresholds are parameters in temperature-code units.

Top module: `thermal_supervisor`

## Requirements
- R1: While reset is active, and on the first cycle after it, `foldback`, `ot_latched` and `rearm_ack` are all 0.
- R2: `temp_code` is registered once. A code presented before clock edge k is first used in the decisions at edge k+1, so outputs can reflect it after edge k+1.
- R3: When `foldback` is 0 and the registered code is strictly greater than FOLD_ON, `foldback` becomes 1 on the next edge. At a code equal to FOLD_ON it stays 0.
- R4: When `foldback` is 1, it stays 1 while the registered code is at least FOLD_ON minus FOLD_HYS. It returns to 0 on the next edge once the code is below that value.
- R5: A registered code at or above TRIP sets `ot_latched` on the next edge. The latch then holds regardless of later temperature until a reset request is granted.
- R6: A 0-to-1 transition of `rearm_from_enable` while the fault is latched is granted when the registered code is below TRIP. On the next edge `ot_latched` drops to 0 and `rearm_ack` is 1 for exactly one cycle.
- R7: A 0-to-1 transition of `rearm_from_disable` while the fault is latched is granted only when the registered code is below TRIP minus TRIP_HYS. A code in the band from TRIP minus TRIP_HYS up to TRIP-1 refuses it.
- R8: A refused request leaves `ot_latched` at 1 and `rearm_ack` at 0. Holding a request input high does not retry it; only a new 0-to-1 transition is judged again.
- R9: A request arriving while no fault is latched produces no `rearm_ack` and changes neither `ot_latched` nor `foldback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TEMP_W | Junction temperature code, larger means hotter |
| rearm_from_disable | input | 1 | Fault-clear request from the disable path (strict rule), acts on its rising edge |
| rearm_from_enable | input | 1 | Fault-clear request from the enable path (relaxed rule), acts on its rising edge |
| foldback | output | 1 | Requests the reduced current-limit threshold |
| ot_latched | output | 1 | Overtemperature fault latched, outputs must be off |
| rearm_ack | output | 1 | One-cycle pulse when a clear request is granted |

## Verification
The bench builds the block with an 8-bit code, FOLD_ON 170, FOLD_HYS 4, TRIP 185 and TRIP_HYS 12. This places the foldback release at 166 and the strict clear limit at 173. All of these sit inside a random walk over 140 to 215, so random stimulus keeps crossing each boundary in both directions. With these values the 173..184 band, where only an enable-path clear succeeds, is wide enough for directed steps to land on each side of every edge.

// File: rtl/thermsup_pkg.sv
package thermsup_pkg;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'd0,
        CLR_RELAXED = 2'd1,
        CLR_STRICT  = 2'd2
    } clr_src_e;

    // The relaxed path wins when both requests rise together, since it is the
    // looser of the two rules and the union of both grants is the intent.
    function automatic clr_src_e pick_source(input logic relaxed_edge,
                                             input logic strict_edge);
        if (relaxed_edge)
            return CLR_RELAXED;
        else if (strict_edge)
            return CLR_STRICT;
        else
            return CLR_NONE;
    endfunction

endpackage

// File: rtl/ts_edge.sv
module ts_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = level;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = level[i] & ~s_q.prev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // R8: a line held high yields no second rising pulse
    assert_no_repeat_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level[0] && $past(level[0])) |-> !rise[0]);

endmodule

// File: rtl/ts_fold.sv
module ts_fold #(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned FOLD_ON  = 170,
    parameter int unsigned FOLD_HYS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              fold
);
    localparam logic [TEMP_W-1:0] ON_C  = TEMP_W'(FOLD_ON);
    localparam logic [TEMP_W-1:0] REL_C = TEMP_W'(FOLD_ON - FOLD_HYS);

    typedef struct packed {
        logic fold;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.fold)
            s_d.fold = (temp >= REL_C);
        else
            s_d.fold = (temp > ON_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign fold = s_q.fold;

    assert_fold_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (temp > ON_C) |=> fold);

    assert_fold_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fold && temp >= REL_C) |=> fold);

    assert_fold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fold && temp <= ON_C) |=> !fold);

    assert_fold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (temp < REL_C) |=> !fold);

endmodule

// File: rtl/ts_trip.sv
module ts_trip
    import thermsup_pkg::*;
#(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned TRIP     = 185,
    parameter int unsigned TRIP_HYS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    input  logic              relaxed_edge,
    input  logic              strict_edge,
    output logic              ot,
    output logic              ack
);
    localparam logic [TEMP_W-1:0] TRIP_C   = TEMP_W'(TRIP);
    localparam logic [TEMP_W-1:0] STRICT_C = TEMP_W'(TRIP - TRIP_HYS);

    typedef struct packed {
        logic ot;
        logic ack;
    } state_t;

    state_t   s_d, s_q;
    clr_src_e src;
    logic     grant;

    always_comb begin
        src = pick_source(relaxed_edge, strict_edge);
        unique case (src)
            CLR_RELAXED: grant = (temp < TRIP_C) || (strict_edge && temp < STRICT_C);
            CLR_STRICT:  grant = (temp < STRICT_C);
            default:     grant = 1'b0;
        endcase
        grant = grant && s_q.ot;

        s_d     = s_q;
        s_d.ack = 1'b0;
        if (temp >= TRIP_C) begin
            s_d.ot = 1'b1;
        end else if (grant) begin
            s_d.ot  = 1'b0;
            s_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ot  = s_q.ot;
    assign ack = s_q.ack;

    assert_trip_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp >= TRIP_C) |=> ot);

    assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ot && !relaxed_edge && !strict_edge) |=> ot);

    assert_ack_needs_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(ot));

    assert_ack_below_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(temp) < TRIP_C));

    assert_strict_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(!relaxed_edge)) |-> ($past(temp) < STRICT_C));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

// File: rtl/thermal_supervisor.sv
module thermal_supervisor #(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned FOLD_ON  = 170,
    parameter int unsigned FOLD_HYS = 4,
    parameter int unsigned TRIP     = 185,
    parameter int unsigned TRIP_HYS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              rearm_from_disable,
    input  logic              rearm_from_enable,
    output logic              foldback,
    output logic              ot_latched,
    output logic              rearm_ack
);
    localparam int unsigned REQ_N = 2;

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
    } state_t;

    state_t           s_d, s_q;
    logic [REQ_N-1:0] req_level;
    logic [REQ_N-1:0] req_rise;

    always_comb begin
        s_d      = s_q;
        s_d.temp = temp_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // index 0: enable path, index 1: disable path
    assign req_level = {rearm_from_disable, rearm_from_enable};

    ts_edge #(.N(REQ_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (req_level),
        .rise  (req_rise)
    );

    ts_fold #(
        .TEMP_W   (TEMP_W),
        .FOLD_ON  (FOLD_ON),
        .FOLD_HYS (FOLD_HYS)
    ) u_fold (
        .clk   (clk),
        .rst_n (rst_n),
        .temp  (s_q.temp),
        .fold  (foldback)
    );

    ts_trip #(
        .TEMP_W   (TEMP_W),
        .TRIP     (TRIP),
        .TRIP_HYS (TRIP_HYS)
    ) u_trip (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp         (s_q.temp),
        .relaxed_edge (req_rise[0]),
        .strict_edge  (req_rise[1]),
        .ot           (ot_latched),
        .ack          (rearm_ack)
    );

    // R2: the decisions follow the code registered one edge earlier
    assert_sample_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(temp_code) > TEMP_W'(FOLD_ON)) |=> foldback);

endmodule

// File: tb/sim_thermal_supervisor.sv
module sim_thermal_supervisor;
    localparam int W    = 8;
    localparam int FON  = 170;
    localparam int FHY  = 4;
    localparam int TRP  = 185;
    localparam int THY  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] temp_code = '0;
    logic dis_req = 1'b0;
    logic en_req = 1'b0;
    logic foldback, ot_latched, rearm_ack;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state
    int  m_temp = 0;
    bit  m_en_prev = 0, m_dis_prev = 0;
    bit  m_fold = 0, m_ot = 0, m_ack = 0;

    always #4 clk = ~clk;

    thermal_supervisor #(
        .TEMP_W(W), .FOLD_ON(FON), .FOLD_HYS(FHY), .TRIP(TRP), .TRIP_HYS(THY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
        .rearm_from_disable(dis_req), .rearm_from_enable(en_req),
        .foldback(foldback), .ot_latched(ot_latched), .rearm_ack(rearm_ack)
    );

    function automatic bit fold_next(bit f, int t);
        return f ? (t >= FON - FHY) : (t > FON);
    endfunction

    function automatic bit grant_ok(bit ot, bit en_rise, bit dis_rise, int t);
        return ot && ((en_rise && t < TRP) || (dis_rise && t < TRP - THY));
    endfunction

    task automatic check1(string tag, string name, logic got, bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%b expected=%b time=%0t", tag, name, got, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check1(tag, "foldback", foldback, m_fold);
        check1(tag, "ot_latched", ot_latched, m_ot);
        check1(tag, "rearm_ack", rearm_ack, m_ack);
    endtask

    // called at a negative edge: drive, advance the reference, wait, compare
    task automatic step(int t, bit en, bit dis, string tag);
        bit er, dr, g;
        temp_code = W'(t);
        en_req = en;
        dis_req = dis;
        er = en && !m_en_prev;
        dr = dis && !m_dis_prev;
        g = grant_ok(m_ot, er, dr, m_temp);
        m_fold = fold_next(m_fold, m_temp);
        if (m_temp >= TRP) begin
            m_ot = 1; m_ack = 0;
        end else if (g) begin
            m_ot = 0; m_ack = 1;
        end else begin
            m_ack = 0;
        end
        m_temp = t;
        m_en_prev = en;
        m_dis_prev = dis;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step(100, 0, 0, "R1");

        // R2: latency of two edges from pin to output
        step(175, 0, 0, "R2");
        check1("R2", "foldback early", foldback, 1'b0);
        step(175, 0, 0, "R2");
        check1("R2", "foldback late", foldback, 1'b1);

        // R3: threshold is strictly greater
        step(160, 0, 0, "R3"); step(160, 0, 0, "R3"); step(160, 0, 0, "R3");
        check1("R3", "foldback cool", foldback, 1'b0);
        step(170, 0, 0, "R3"); step(170, 0, 0, "R3");
        check1("R3", "foldback at FOLD_ON", foldback, 1'b0);
        step(171, 0, 0, "R3"); step(171, 0, 0, "R3");
        check1("R3", "foldback above", foldback, 1'b1);

        // R4: hysteresis hold and release
        step(166, 0, 0, "R4"); step(166, 0, 0, "R4"); step(166, 0, 0, "R4");
        check1("R4", "foldback held", foldback, 1'b1);
        step(165, 0, 0, "R4"); step(165, 0, 0, "R4");
        check1("R4", "foldback released", foldback, 1'b0);

        // R5: trip latch holds after cooling
        step(185, 0, 0, "R5"); step(120, 0, 0, "R5");
        check1("R5", "ot_latched set", ot_latched, 1'b1);
        for (int i = 0; i < 5; i++) step(120, 0, 0, "R5");
        check1("R5", "ot_latched held", ot_latched, 1'b1);

        // R6: relaxed clear at 184 (just below trip)
        step(200, 0, 0, "R6"); step(184, 0, 0, "R6"); step(184, 0, 0, "R6");
        step(184, 1, 0, "R6");
        check1("R6", "ack pulse", rearm_ack, 1'b1);
        check1("R6", "latch cleared", ot_latched, 1'b0);
        step(184, 1, 0, "R6");
        check1("R6", "ack one cycle", rearm_ack, 1'b0);
        step(184, 0, 0, "R6");

        // R7: strict clear refused at 173, granted at 172
        step(190, 0, 0, "R7"); step(173, 0, 0, "R7"); step(173, 0, 0, "R7");
        step(173, 0, 1, "R7");
        check1("R7", "strict refused", ot_latched, 1'b1);
        step(172, 0, 0, "R7"); step(172, 0, 0, "R7");
        step(172, 0, 1, "R7");
        check1("R7", "strict granted", rearm_ack, 1'b1);
        step(172, 0, 0, "R7");

        // R8: refused while hot, held high does not retry
        step(195, 0, 0, "R8"); step(195, 1, 0, "R8");
        for (int i = 0; i < 6; i++) step(150, 1, 0, "R8");
        check1("R8", "held no retry", ot_latched, 1'b1);
        step(150, 0, 0, "R8");
        step(150, 1, 0, "R8");
        check1("R8", "new edge grants", rearm_ack, 1'b1);

        // R9: requests with no fault
        step(150, 0, 0, "R9");
        step(150, 1, 1, "R9");
        check1("R9", "no ack idle", rearm_ack, 1'b0);
        step(150, 0, 0, "R9");
        step(150, 0, 1, "R9");
        check1("R9", "no latch change", ot_latched, 1'b0);

        // random walk across all thresholds
        t = 170;
        for (int i = 0; i < 4000; i++) begin
            t = t + int'($urandom % 9) - 4;
            if (t < 140) t = 140;
            if (t > 215) t = 215;
            step(t, ($urandom % 6) == 0, ($urandom % 5) == 0, "R5/R6/R7 random");
        end

        finish_run();
    end
endmodule